// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a synchronous flow-through static RAM whose data bus can change direction on any cycle. Address, controls, byte-write enables and write data are all captured on the rising clock edge. On a cycle with the advance input low, the block takes a fresh external address and starts a read, a write or a deselect. With advance high, it steps a two-bit beat counter across the lowest address bits while the upper bits stay put. The beat order is linear or interleaved, chosen by a pin that is sampled when the address is loaded.

Read data leaves the array in the cycle after the command edge. Write data arrives one edge after its command. It waits in a pending register and reaches the array one active edge later. Any read that hits the pending address gets the pending bytes merged in, so a read can follow a write with no gap, and a write can follow a read. A hold input freezes every register. Three chip enables must all be active for an access. A controller state machine has three states. ST_IDLE means no access is in progress. ST_READ means the current beat drives read data. ST_WRITE means the current beat expects write data at the next edge. Transitions happen only on an active edge with advance low: to ST_IDLE when any enable is inactive, to ST_WRITE when enabled with write-enable low, and to ST_READ when enabled with write-enable high. When advance is high, or the hold input is high, the state stays where it is.

Top module: `zbt_sram_model`

## Requirements
- R1: A read command registered at edge N drives its data on rdata, with rdata_vld high, during the cycle that follows edge N. There is no extra latency.
- R2: While hold is high at an edge, no register changes: the state, the burst address, the pending write and the array keep their values, and the outputs do not change.
- R3: An active edge with adv low loads addr as the access address and starts a new read, write or deselect.
- R4: An active edge with adv high during a read or write moves to the next beat. Address bits above bit 1 stay fixed, and after the fourth beat the order wraps back to the start offset.
- R5: With burst_ilv low at the load edge, beat k uses offset (start + k) mod 4.
- R6: With burst_ilv high at the load edge, beat k uses offset start XOR k.
- R7: Write data for a write beat registered at edge N is sampled at edge N+1. Only byte i, bits 8i+7 down to 8i, with byte_wr_n[i] low at edge N is updated.
- R8: An access needs en_a_n low, en_b high and en_c_n low at the load edge. Otherwise the cycle is a deselect: nothing is written and rdata_vld stays low.
- R9: Reads and writes alternate back to back with no idle cycle. A read of the address still pending from a write returns the new bytes merged with the old ones.
- R10: rdata_vld is low, and rdata is all zeros, whenever oe_n is high, during a write beat, or after a deselect.
- R11: After reset the state is ST_IDLE, rdata_vld is low and every word of the array reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | High freezes all state (clock enable, active low) |
| adv | input | 1 | Low loads a new address and command, high steps the burst |
| wr_n | input | 1 | Low selects a write at a load edge |
| byte_wr_n | input | BYTES | Per-byte write enables, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| burst_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Write data |
| rdata | output | BYTES*BYTE_W | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is being driven (low models a high-impedance bus) |

## Verification
The properties assume that rst_n is released synchronously and that hold, adv, the enables and wr_n are stable around each rising edge. They also assume that oe_n changes only between edges, because rdata_vld follows it without a register. The bench drives every input at the falling edge and checks outputs just before the next change, so each sample sees settled inputs. Random addresses stay within sixteen words, so reads often land on the word a write has just left pending.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zbt_state_e;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             adv,
    input  logic             wr_n,
    input  logic             sel_ok,
    input  logic [BYTES-1:0] byte_wr_n,
    output zbt_state_e       state_q,
    output logic             load_o,
    output logic             step_o,
    output logic             cap_o,
    output logic [BYTES-1:0] wmask_q
);
    zbt_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!hold && !adv) begin
            if (!sel_ok)
                state_d = ST_IDLE;
            else if (!wr_n)
                state_d = ST_WRITE;
            else
                state_d = ST_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // byte enables travel with each beat and are used one edge later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wmask_q <= '0;
        else if (!hold)
            wmask_q <= ~byte_wr_n;
    end

    always_comb begin
        load_o = !hold && !adv;
        step_o = 1'b0;
        cap_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  step_o = 1'b0;
            ST_READ:  step_o = !hold && adv;
            ST_WRITE: begin
                step_o = !hold && adv;
                cap_o  = !hold;
            end
            default:  step_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/zbt_burst.sv
module zbt_burst #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              ilv_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int UP_W = ADDR_W - 2;

    logic [UP_W-1:0] upper_q;
    logic [1:0]      start_q;
    logic [1:0]      beat_q;
    logic            ilv_q;
    logic [1:0]      offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:2];
            start_q <= addr_in[1:0];
            beat_q  <= '0;
            ilv_q   <= ilv_in;
        end else if (step) begin
            beat_q  <= beat_q + 2'd1;
        end
    end

    always_comb begin
        if (ilv_q)
            offset = start_q ^ beat_q;
        else
            offset = start_q + beat_q;
    end

    assign eff_addr = {upper_q, offset};
endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    cap,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [BYTES-1:0]        wmask,
    output logic [BYTES*BYTE_W-1:0] rword
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = BYTES * BYTE_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_data;
    logic [BYTES-1:0]  pend_mask;
    logic              pend_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            pend_mask <= '0;
        end else if (!hold) begin
            if (pend_vld) begin
                for (int b = 0; b < BYTES; b++)
                    if (pend_mask[b])
                        mem[pend_addr][b*BYTE_W +: BYTE_W] <= pend_data[b*BYTE_W +: BYTE_W];
            end
            pend_vld <= cap;
            if (cap) begin
                pend_addr <= acc_addr;
                pend_data <= wdata;
                pend_mask <= wmask;
            end
        end
    end

    assign pend_hit = pend_vld && (pend_addr == acc_addr);

    for (genvar g = 0; g < BYTES; g++) begin : g_merge
        assign rword[g*BYTE_W +: BYTE_W] = (pend_hit && pend_mask[g])
            ? pend_data[g*BYTE_W +: BYTE_W]
            : mem[acc_addr][g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/zbt_sram_model.sv
module zbt_sram_model
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    adv,
    input  logic                    wr_n,
    input  logic [BYTES-1:0]        byte_wr_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rdata_vld
);
    localparam int WORD_W = BYTES * BYTE_W;

    zbt_state_e        state_q;
    logic              sel_ok;
    logic              load;
    logic              step;
    logic              cap;
    logic [BYTES-1:0]  wmask_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] rword;

    assign sel_ok = !en_a_n && en_b && !en_c_n;

    zbt_ctrl #(.BYTES(BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .adv       (adv),
        .wr_n      (wr_n),
        .sel_ok    (sel_ok),
        .byte_wr_n (byte_wr_n),
        .state_q   (state_q),
        .load_o    (load),
        .step_o    (step),
        .cap_o     (cap),
        .wmask_q   (wmask_q)
    );

    zbt_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ilv_in   (burst_ilv),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    zbt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .cap      (cap),
        .acc_addr (eff_addr),
        .wdata    (wdata),
        .wmask    (wmask_q),
        .rword    (rword)
    );

    assign rdata_vld = (state_q == ST_READ) && !oe_n;
    assign rdata     = rdata_vld ? rword : '0;
endmodule

// File: rtl/zbt_sram_checks.sv
module zbt_sram_checks
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              adv,
    input logic              wr_n,
    input logic              en_a_n,
    input logic              en_b,
    input logic              en_c_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rdata_vld,
    input zbt_state_e        state_q,
    input logic [ADDR_W-1:0] eff_addr
);
    logic all_on;
    assign all_on = !en_a_n && en_b && !en_c_n;

    assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(state_q) && $stable(eff_addr)));

    assert_load_takes_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv) |=> (eff_addr == $past(addr)));

    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv && state_q != ST_IDLE) |=> $stable(eff_addr[ADDR_W-1:2]));

    assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv && !all_on) |=> !rdata_vld);

    assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv && all_on && wr_n) |=> (rdata_vld || oe_n));

    assert_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE || oe_n) |-> !rdata_vld);
endmodule

bind zbt_sram_model zbt_sram_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .adv       (adv),
    .wr_n      (wr_n),
    .en_a_n    (en_a_n),
    .en_b      (en_b),
    .en_c_n    (en_c_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .rdata_vld (rdata_vld),
    .state_q   (state_q),
    .eff_addr  (eff_addr)
);

// File: tb/zbt_sram_model_test.sv
`timescale 1ns/1ps
module zbt_sram_model_test;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0;
    logic          adv = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] byte_wr_n = '1;
    logic          en_a_n = 1'b1;
    logic          en_b = 1'b0;
    logic          en_c_n = 1'b1;
    logic          burst_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rdata;
    logic          rdata_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 read, 2 write
    int            r_op = 0;
    logic [AW-3:0] r_up = '0;
    logic [1:0]    r_start = '0;
    logic [1:0]    r_beat = '0;
    logic          r_ilv = 1'b0;
    logic [NB-1:0] r_bwn = '1;
    logic [WW-1:0] r_mem [1<<AW];

    always #5 clk = ~clk;

    zbt_sram_model #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .wr_n(wr_n),
        .byte_wr_n(byte_wr_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    function automatic logic [AW-1:0] ref_addr();
        logic [1:0] off;
        off = r_ilv ? (r_start ^ r_beat) : (r_start + r_beat);
        return {r_up, off};
    endfunction

    function automatic logic [WW-1:0] merge_bytes(logic [WW-1:0] old_w,
                                                  logic [WW-1:0] new_w,
                                                  logic [NB-1:0] bwn);
        logic [WW-1:0] res;
        res = old_w;
        for (int b = 0; b < NB; b++)
            if (!bwn[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
        return res;
    endfunction

    task automatic check(input string tag, input logic got_v, input logic [WW-1:0] got_d,
                         input logic exp_v, input logic [WW-1:0] exp_d);
        n_chk++;
        if (got_v !== exp_v || got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     tag, got_v, got_d, exp_v, exp_d);
        end
    endtask

    // sel: 0 all enables active, 1/2/3 drop one of them
    task automatic step(input logic a_hold, input logic a_adv, input logic a_wrn,
                        input logic [NB-1:0] a_bwn, input int sel, input logic a_oen,
                        input logic a_ilv, input logic [AW-1:0] a_addr,
                        input logic [WW-1:0] a_wd, input string tag);
        logic exp_v;
        hold = a_hold; adv = a_adv; wr_n = a_wrn; byte_wr_n = a_bwn;
        en_a_n = (sel == 1); en_b = (sel != 2); en_c_n = (sel == 3);
        oe_n = a_oen; burst_ilv = a_ilv; addr = a_addr; wdata = a_wd;
        @(posedge clk);
        if (!a_hold) begin
            if (r_op == 2) r_mem[ref_addr()] = merge_bytes(r_mem[ref_addr()], a_wd, r_bwn);
            r_bwn = a_bwn;
            if (!a_adv) begin
                r_op = (sel != 0) ? 0 : (a_wrn ? 1 : 2);
                r_up = a_addr[AW-1:2]; r_start = a_addr[1:0]; r_beat = '0; r_ilv = a_ilv;
            end else if (r_op != 0) begin
                r_beat = r_beat + 2'd1;
            end
        end
        @(negedge clk);
        exp_v = (r_op == 1) && !a_oen;
        check(tag, rdata_vld, rdata, exp_v, exp_v ? r_mem[ref_addr()] : '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: vld=%0b data=%h expected run to end", rdata_vld, rdata);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < (1<<AW); i++) r_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset idle", rdata_vld, rdata, 1'b0, '0);

        // R11: unwritten word reads zero; R1: read data in the following cycle
        step(0,0,1,4'hF,0,0,0,6'd21,'0,"R11 zero array");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R1 beat 2");

        // R7: linear write burst at 4..7, data follows each beat by one edge
        step(0,0,0,4'h0,0,0,0,6'd4,32'hDEAD0000,"R7 write load");
        step(0,1,0,4'h0,0,0,0,6'd0,32'h11111111,"R7 write beat");
        step(0,1,0,4'h0,0,0,0,6'd0,32'h22222222,"R7 write beat");
        step(0,1,0,4'h0,0,0,0,6'd0,32'h33333333,"R7 write beat");
        // R9: read starts while last write data is captured
        step(0,0,1,4'hF,0,0,0,6'd5,32'h44444444,"R9 write to read");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R5 linear beat");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R5 linear beat");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R5 linear beat");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R4 wrap to start");
        // R6: interleaved from offset 1
        step(0,0,1,4'hF,0,0,1,6'd5,'0,"R6 ilv load");
        step(0,1,1,4'hF,0,0,1,6'd0,'0,"R6 ilv beat");
        step(0,1,1,4'hF,0,0,1,6'd0,'0,"R6 ilv beat");
        step(0,1,1,4'hF,0,0,1,6'd0,'0,"R6 ilv beat");
        step(0,1,1,4'hF,0,0,1,6'd0,'0,"R4 ilv wrap");

        // R7/R9: masked write then immediate read of the pending word
        step(0,0,0,4'b1010,0,0,0,6'd5,'0,"R7 masked write");
        step(0,0,1,4'hF,0,0,0,6'd5,32'hA5C3B4D2,"R9 pending merge");
        step(0,0,1,4'hF,0,0,0,6'd5,'0,"R7 masked committed");
        // R9: read to write to read back-to-back
        step(0,0,0,4'h0,0,0,0,6'd6,'0,"R9 read to write");
        step(0,0,1,4'hF,0,0,0,6'd6,32'h0BADF00D,"R9 write to read");

        // R2: hold freezes everything
        step(0,0,1,4'hF,0,0,0,6'd4,'0,"R2 read before hold");
        step(1,0,0,4'h0,0,0,1,6'd9,32'hFFFFFFFF,"R2 held");
        step(1,1,0,4'h0,2,0,1,6'd12,32'hFFFFFFFF,"R2 held");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R2 resumes");
        step(0,0,0,4'h0,0,0,0,6'd8,'0,"R2 write load");
        step(1,0,1,4'hF,0,0,0,6'd8,32'h77777777,"R2 held write");
        step(0,0,1,4'hF,0,0,0,6'd8,32'h12345678,"R2 write data after hold");

        // R8: each enable alone blocks a write
        step(0,0,0,4'h0,1,0,0,6'd8,'0,"R8 drop a");
        step(0,1,0,4'h0,1,0,0,6'd8,32'h99999999,"R8 deselect data");
        step(0,0,0,4'h0,2,0,0,6'd8,32'h99999999,"R8 drop b");
        step(0,0,0,4'h0,3,0,0,6'd8,32'h99999999,"R8 drop c");
        step(0,0,1,4'hF,0,0,0,6'd8,32'h99999999,"R8 word intact");

        // R10: output enable high during a read
        step(0,0,1,4'hF,0,1,0,6'd8,'0,"R10 oe high");
        step(0,1,1,4'hF,0,0,0,6'd0,'0,"R10 oe low again");

        // R1: constrained random mix
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int k = 0; k < 600; k++) begin
            logic r_hold, r_adv;
            r_hold = ($urandom % 10) == 0;
            r_adv  = ($urandom % 2) == 0;
            step(r_hold, r_adv, logic'($urandom % 2), 4'($urandom), (($urandom % 8) == 0) ? int'($urandom % 3) + 1 : 0,
                 ($urandom % 8) == 0, logic'($urandom % 2), 6'($urandom % 16), $urandom, "R1 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule